// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block carries out register-to-register copy and swap operations for a CPU register set with 8-bit and 16-bit registers. An external sequencer supplies a one-byte operand and a start strobe. The operand names two registers, one in each half. A select input chooses between a copy and a swap. A mode input chooses between the compatibility timing and the faster native timing.

The block holds the register file: accumulators A and B, the 16-bit pair D formed from them, index registers X and Y, stack pointers U and S, PC, CC and DP. A load port lets the sequencer preset any register while no operation is running.

An illegal operand is refused and flagged for one cycle. This covers an unassigned register code and a pairing of registers of different widths. A legal operation runs for the cycle count of its mode and writes its result on the cycle its done pulse is high.

Top module: `regxfer_unit`

## Requirements
- R1: Bits [7:4] of `post` select the source register and bits [3:0] select the destination. The register codes are: D=0, X=1, Y=2, U=3, S=4, PC=5 (16-bit); A=8, B=9, CC=10, DP=11 (8-bit). Codes 6, 7 and 12 to 15 are unassigned.
- R2: With `swap`=0, the destination receives the source value and the source register keeps its value.
- R3: With `swap`=1, the two registers trade values.
- R4: D reads as {A,B}. Writing D sets A to its high byte and B to its low byte, and a write to A or B shows up in D.
- R5: If one selected register is 8-bit and the other is 16-bit, `illegal` goes high for exactly one cycle after the accepting edge. No register changes and `busy` stays low.
- R6: A post byte with an unassigned code in either half is handled the same way as in R5.
- R7: A legal operation raises `done` in the Nth cycle after the accepting edge. N is 6 when `native`=0 and 4 when `native`=1, and `cyc_len` shows N for the current `native` input. Registers take the result at the edge that ends the `done` cycle.
- R8: A completed operation writes only the registers it names. In particular, CC changes only when CC is one of the selected registers.
- R9: When source and destination are the same register, its value does not change under either copy or swap.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: When `busy` is low, `ld_en` writes `ld_val` into the register named by `ld_code` (8-bit registers take the low byte). It is ignored while `busy` is high and for unassigned codes.
- R12: After reset every register reads zero and `busy`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation using `post` and `swap` |
| swap | input | 1 | 0 = copy, 1 = swap |
| native | input | 1 | Timing mode: 0 = 6 cycles, 1 = 4 cycles |
| post | input | 8 | Source code [7:4], destination code [3:0] |
| ld_en | input | 1 | Direct register load strobe |
| ld_code | input | 4 | Register code for the load |
| ld_val | input | 16 | Load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation; writeback at its end |
| illegal | output | 1 | One-cycle pulse for a refused post byte |
| cyc_len | output | 3 | Cycle count for the current mode |
| a_q | output | 8 | Accumulator A |
| b_q | output | 8 | Accumulator B |
| x_q | output | 16 | Index X |
| y_q | output | 16 | Index Y |
| u_q | output | 16 | Stack pointer U |
| s_q | output | 16 | Stack pointer S |
| pc_q | output | 16 | Program counter |
| cc_q | output | 8 | Condition codes |
| dp_q | output | 8 | Direct page |

## Verification
Two of the block's functions can fall in the same cycle: a direct load and the start of an operation.

- **Load together with start.** The bench pulses `ld_en` and `start` in the same cycle, with the load aimed at the source register. The operation reads its operands at writeback, so the copied value must be the freshly loaded one.
- **Load during an operation.** The bench loads while `busy` is high and also attempts a second `start`. The first destination must show the first operation's result, untouched by the late load or the refused start.

// File: rtl/regxfer_unit.sv
module regxfer_unit #(
  parameter int COMPAT_CYC = 6,
  parameter int NATIVE_CYC = 4,
  parameter int CW = $clog2(COMPAT_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        swap,
  input  logic        native,
  input  logic [7:0]  post,
  input  logic        ld_en,
  input  logic [3:0]  ld_code,
  input  logic [15:0] ld_val,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic [CW-1:0] cyc_len,
  output logic [7:0]  a_q,
  output logic [7:0]  b_q,
  output logic [15:0] x_q,
  output logic [15:0] y_q,
  output logic [15:0] u_q,
  output logic [15:0] s_q,
  output logic [15:0] pc_q,
  output logic [7:0]  cc_q,
  output logic [7:0]  dp_q
);

  logic [15:0] r16 [1:5];
  logic [7:0]  r8  [8:11];
  logic [15:0] n16 [1:5];
  logic [7:0]  n8  [8:11];
  logic [CW-1:0] cnt;
  logic [7:0]  post_q;
  logic        swap_q;
  logic [15:0] src_v, dst_v;
  logic [3:0]  wc [0:2];
  logic [15:0] wv [0:2];
  logic        we [0:2];

  function automatic logic known(input logic [3:0] c);
    return (c <= 4'd5) || (c >= 4'd8 && c <= 4'd11);
  endfunction

  wire legal  = known(post[7:4]) && known(post[3:0]) && (post[7] == post[3]);
  wire accept = start && !busy;

  assign done    = busy && (cnt == '0);
  assign cyc_len = native ? CW'(NATIVE_CYC) : CW'(COMPAT_CYC);

  function automatic logic [15:0] pick(input logic [3:0] c,
      input logic [15:0] x, y, u, s, pc, input logic [7:0] a, b, cc, dp);
    case (c)
      4'd0:  return {a, b};
      4'd1:  return x;
      4'd2:  return y;
      4'd3:  return u;
      4'd4:  return s;
      4'd5:  return pc;
      4'd8:  return {8'h00, a};
      4'd9:  return {8'h00, b};
      4'd10: return {8'h00, cc};
      4'd11: return {8'h00, dp};
      default: return 16'h0000;
    endcase
  endfunction

  assign src_v = pick(post_q[7:4], r16[1], r16[2], r16[3], r16[4], r16[5],
                      r8[8], r8[9], r8[10], r8[11]);
  assign dst_v = pick(post_q[3:0], r16[1], r16[2], r16[3], r16[4], r16[5],
                      r8[8], r8[9], r8[10], r8[11]);

  always_comb begin
    n16 = r16;
    n8  = r8;
    wc[0] = ld_code;      wv[0] = ld_val; we[0] = ld_en && !busy;
    wc[1] = post_q[3:0];  wv[1] = src_v;  we[1] = done;
    wc[2] = post_q[7:4];  wv[2] = dst_v;  we[2] = done && swap_q;
    for (int k = 0; k < 3; k++) begin
      if (we[k]) begin
        case (wc[k])
          4'd0:  begin n8[8] = wv[k][15:8]; n8[9] = wv[k][7:0]; end
          4'd1:  n16[1] = wv[k];
          4'd2:  n16[2] = wv[k];
          4'd3:  n16[3] = wv[k];
          4'd4:  n16[4] = wv[k];
          4'd5:  n16[5] = wv[k];
          4'd8:  n8[8]  = wv[k][7:0];
          4'd9:  n8[9]  = wv[k][7:0];
          4'd10: n8[10] = wv[k][7:0];
          4'd11: n8[11] = wv[k][7:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 5; i++) r16[i] <= '0;
      for (int i = 8; i <= 11; i++) r8[i] <= '0;
      busy    <= 1'b0;
      illegal <= 1'b0;
      cnt     <= '0;
      post_q  <= '0;
      swap_q  <= 1'b0;
    end else begin
      r16     <= n16;
      r8      <= n8;
      illegal <= 1'b0;
      if (accept) begin
        if (legal) begin
          busy   <= 1'b1;
          cnt    <= native ? CW'(NATIVE_CYC - 1) : CW'(COMPAT_CYC - 1);
          post_q <= post;
          swap_q <= swap;
        end else begin
          illegal <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign x_q  = r16[1];
  assign y_q  = r16[2];
  assign u_q  = r16[3];
  assign s_q  = r16[4];
  assign pc_q = r16[5];
  assign a_q  = r8[8];
  assign b_q  = r8[9];
  assign cc_q = r8[10];
  assign dp_q = r8[11];

endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ld_en,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic [7:0] cc_q
);

  // R5
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  // R5
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy);

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  start_reacts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || illegal));

  // R8
  cc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !(ld_en && !busy)) |=> $stable(cc_q));

endmodule

bind regxfer_unit regxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en),
  .busy(busy), .done(done), .illegal(illegal), .cc_q(cc_q)
);

// File: tb/sim_regxfer_unit.sv
module sim_regxfer_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, swap = 0, native = 0, ld_en = 0;
  logic [7:0] post = 0;
  logic [3:0] ld_code = 0;
  logic [15:0] ld_val = 0;
  logic busy, done, illegal;
  logic [2:0] cyc_len;
  logic [7:0] a_q, b_q, cc_q, dp_q;
  logic [15:0] x_q, y_q, u_q, s_q, pc_q;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regxfer_unit u0 (.*);

  // {swap, native, illegal, post, expected dst, expected src}
  localparam logic [42:0] VEC [11] = '{
    {1'b0, 1'b0, 1'b0, 8'h89, 16'h0011, 16'h0011},
    {1'b0, 1'b1, 1'b0, 8'h12, 16'h1111, 16'h1111},
    {1'b0, 1'b0, 1'b0, 8'h01, 16'h1122, 16'h1122},
    {1'b1, 1'b1, 1'b0, 8'h13, 16'h1111, 16'h3333},
    {1'b1, 1'b0, 1'b0, 8'h8A, 16'h0011, 16'h0066},
    {1'b0, 1'b1, 1'b1, 8'h90, 16'h1122, 16'h0022},
    {1'b0, 1'b0, 1'b1, 8'h61, 16'h1111, 16'h0000},
    {1'b1, 1'b1, 1'b0, 8'h44, 16'h4444, 16'h4444},
    {1'b0, 1'b0, 1'b0, 8'h10, 16'h1111, 16'h1111},
    {1'b1, 1'b1, 1'b0, 8'hB9, 16'h0077, 16'h0022},
    {1'b0, 1'b0, 1'b1, 8'h5C, 16'h0000, 16'h5555}
  };

  function automatic logic [15:0] peek(input logic [3:0] c);
    case (c)
      4'd0: return {a_q, b_q};
      4'd1: return x_q;   4'd2: return y_q;  4'd3: return u_q;
      4'd4: return s_q;   4'd5: return pc_q;
      4'd8: return {8'h0, a_q};  4'd9:  return {8'h0, b_q};
      4'd10: return {8'h0, cc_q}; 4'd11: return {8'h0, dp_q};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] c, input logic [15:0] v);
    ld_en = 1; ld_code = c; ld_val = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic preset();
    load(4'd8, 16'h0011); load(4'd9, 16'h0022); load(4'd1, 16'h1111);
    load(4'd2, 16'h2222); load(4'd3, 16'h3333); load(4'd4, 16'h4444);
    load(4'd5, 16'h5555); load(4'd10, 16'h0066); load(4'd11, 16'h0077);
  endtask

  // returns number of cycles after start until done or illegal
  task automatic run(input logic sw, nat, input logic [7:0] pb, output int n);
    swap = sw; native = nat; post = pb; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && !illegal && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] pre_y;
    repeat (2) @(negedge clk);
    // R12
    check("R12 regs", {x_q ^ y_q ^ u_q ^ s_q ^ pc_q} | {a_q, b_q} | {cc_q, dp_q}, 16'h0);
    check("R12 flags", {13'b0, busy, done, illegal}, 16'h0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      logic [42:0] v = VEC[i];
      preset();
      run(v[42], v[41], v[39:32], n);
      // R5 R6: illegal pulse in first cycle; R7: done in cycle N
      if (v[40]) begin
        check("R5/R6 illegal", {15'b0, illegal}, 16'h1);
        check("R5/R6 no busy", {15'b0, busy}, 16'h0);
        check("R5/R6 cycle", 16'(n), 16'd1);
      end else begin
        check("R7 cycles", 16'(n), v[41] ? 16'd4 : 16'd6);
        check("R7 cyc_len", {13'b0, cyc_len}, v[41] ? 16'd4 : 16'd6);
      end
      @(negedge clk);
      check("R1 R2 R3 R9 dst", peek(v[35:32]), v[31:16]);
      check("R1 R2 R3 R9 src", peek(v[39:36]), v[15:0]);
      if (v[39:36] != 4'd10 && v[35:32] != 4'd10)
        check("R8 cc held", {8'h0, cc_q}, 16'h0066);
      if (v[39:32] == 8'h10) begin
        check("R4 A from D", {8'h0, a_q}, 16'h0011);
        check("R4 B from D", {8'h0, b_q}, 16'h0011);
      end
      if (v[39:32] == 8'h89)
        check("R8 X held", x_q, 16'h1111);
    end

    // R11 load and start in the same cycle: transfer sees the loaded value
    preset();
    ld_en = 1; ld_code = 4'd1; ld_val = 16'hABCD;
    swap = 0; native = 1; post = 8'h12; start = 1;
    @(negedge clk);
    ld_en = 0; start = 0;
    check("R11 load same cycle", x_q, 16'hABCD);
    repeat (4) @(negedge clk);
    check("R11 transfer after load", y_q, 16'hABCD);

    // R10 R11: start and load while busy are ignored
    preset();
    pre_y = y_q;
    swap = 0; native = 0; post = 8'h13; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    post = 8'h14; start = 1;
    ld_en = 1; ld_code = 4'd2; ld_val = 16'h9999;
    @(negedge clk);
    start = 0; ld_en = 0;
    check("R10 busy kept", {15'b0, busy}, 16'h1);
    repeat (4) @(negedge clk);
    check("R10 U written", u_q, 16'h1111);
    check("R10 S untouched", s_q, 16'h4444);
    check("R11 load ignored busy", y_q, pre_y);
    @(negedge clk);
    check("R10 idle again", {14'b0, busy, illegal}, 16'h0);

    // R11 unassigned load code ignored
    load(4'd7, 16'hFFFF);
    check("R11 bad code X", x_q, 16'h1111);
    check("R11 bad code A", {8'h0, a_q}, 16'h0011);
    // R4 write to A visible in D
    load(4'd8, 16'h00EE);
    check("R4 D from A", peek(4'd0), 16'hEE22);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule